// File: doc/BRIEF.md
# Dual-Bus Dominant Relay Core

This block is the digital heart of a two-port CAN repeater. It reads the comparator levels of two bus receivers, a main and an auxiliary local transmit input, and one active-low receive enable per bus. From these it decides, every clock, whether each bus should be pulled dominant, and it presents two combined receive levels to the local controller. Throughout, logic 0 stands for dominant and logic 1 for recessive.

A dominant seen on either bus is repeated onto the other, with neither side favoured. The repeated dominant then comes back through the receiver of the bus it was sent onto. An echo mask per bus hides that returning level while the block drives the bus and for a short, fixed number of cycles afterwards, so the two buses cannot hold each other dominant forever. Each of the four inputs is also watched by its own stuck-dominant guard that forces the path recessive once it has stayed dominant beyond a timeout.

Top module: `dual_bus_relay`

## Requirements
- R1: While reset is asserted and in the first cycle after it, both drive outputs and both receive outputs are recessive (1).
- R2: While a receive enable (rx_a_en_ni or rx_b_en_ni) is 1, that bus's receive path is recessive whatever its comparator shows; while it is 0 the comparator level passes through.
- R3: The main transmit, auxiliary transmit, bus A receive and bus B receive paths each have a separate timer; a path whose input has been dominant at TIMEOUT_CYC consecutive rising edges reads recessive from then on, without affecting the other paths.
- R4: A timed-out path recovers as soon as its input is recessive at one edge; a fresh dominant on that input passes in the same cycle.
- R5: The drive output of a bus (0 = drive dominant) is registered: it is dominant in the cycle after either timed transmit path, or the other bus's timed, enabled, unmasked receive path, was dominant; the rule is symmetric between the buses.
- R6: While a bus's drive output is dominant, dominant levels received from that bus are not repeated onto the other bus.
- R7: After a bus's drive output returns recessive, reception from that bus stays masked for ECHO_CYC further cycles and is then repeated again.
- R8: rxd_all_o is the AND of the four timed paths and rxd_bus_o is the AND of the two timed receive paths, both in the same cycle and without the echo mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_a_rx_i | input | 1 | Comparator level of bus A (0 = dominant) |
| bus_b_rx_i | input | 1 | Comparator level of bus B (0 = dominant) |
| rx_a_en_ni | input | 1 | Bus A receive enable, active low |
| rx_b_en_ni | input | 1 | Bus B receive enable, active low |
| tx_main_i | input | 1 | Main local transmit level |
| tx_aux_i | input | 1 | Auxiliary local transmit level |
| bus_a_drv_o | output | 1 | Drive request for bus A (0 = dominant) |
| bus_b_drv_o | output | 1 | Drive request for bus B (0 = dominant) |
| rxd_all_o | output | 1 | Combined receive level of all four timed paths |
| rxd_bus_o | output | 1 | Combined receive level of the two bus paths |

## Verification
A timer whose count drifts shows as a receive or drive output turning recessive too early or too late around the TIMEOUT_CYC boundary, or staying recessive after its input was released, visible within one cycle of the boundary. A wrong echo-mask count or a mask placed on the wrong bus shows one cycle later as a drive output repeating its own echo, so both drive outputs lock dominant, or as a genuine dominant from the driven bus being ignored past the ECHO_CYC window. The bench loops each drive output back into its bus receiver, mixes random other-node traffic with directed timeout, enable and echo sequences, and compares all four outputs every cycle against a cycle model built from the requirements.

// File: rtl/relay_pkg.sv
package relay_pkg;
  localparam logic LVL_DOM = 1'b0;
  localparam logic LVL_REC = 1'b1;

  localparam int N_PATH = 4;
  localparam int N_BUS  = 2;

  // path index; receive paths follow bus order
  localparam int P_TXM = 0;
  localparam int P_TXA = 1;
  localparam int P_RXA = 2;
  localparam int P_RXB = 3;
endpackage

// File: rtl/dom_timeout.sv
module dom_timeout #(
  parameter int LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic lvl_o
);
  import relay_pkg::*;

  localparam int TW = $clog2(LIMIT + 1);
  localparam logic [TW-1:0] LIM = TW'(LIMIT);

  logic [TW-1:0] cnt_q;
  logic          expired;

  assign expired = (cnt_q == LIM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (lvl_i == LVL_REC)   cnt_q <= '0;
    else if (!expired)           cnt_q <= cnt_q + 1'b1;
  end

  assign lvl_o = lvl_i | expired;

  p_rec_passes_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_i |-> lvl_o);

  p_fresh_dom_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lvl_i && $past(lvl_i)) |-> !lvl_o);
endmodule

// File: rtl/echo_mask.sv
module echo_mask #(
  parameter int HOLD = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic drv_i,
  output logic mask_o
);
  import relay_pkg::*;

  localparam int EW = $clog2(HOLD + 1);
  localparam logic [EW-1:0] HLD = EW'(HOLD);

  logic [EW-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                hold_q <= '0;
    else if (drv_i == LVL_DOM)  hold_q <= HLD;
    else if (hold_q != '0)      hold_q <= hold_q - 1'b1;
  end

  assign mask_o = (drv_i == LVL_DOM) || (hold_q != '0);

  p_mask_on_drive_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drv_i |-> mask_o);

  p_mask_tail_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drv_i && !$past(drv_i)) |-> mask_o);
endmodule

// File: rtl/dual_bus_relay.sv
module dual_bus_relay #(
  parameter int CLK_HZ      = 200_000_000,
  parameter int TIMEOUT_CYC = CLK_HZ / 40,
  parameter int ECHO_CYC    = CLK_HZ / 250_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_a_rx_i,
  input  logic bus_b_rx_i,
  input  logic rx_a_en_ni,
  input  logic rx_b_en_ni,
  input  logic tx_main_i,
  input  logic tx_aux_i,
  output logic bus_a_drv_o,
  output logic bus_b_drv_o,
  output logic rxd_all_o,
  output logic rxd_bus_o
);
  import relay_pkg::*;

  logic [N_PATH-1:0] raw, timed;
  logic [N_BUS-1:0]  drv_q, drv_d, mask, rx_eff;
  logic              tx_any_rec;

  // disabled receiver reads recessive
  assign raw[P_TXM] = tx_main_i;
  assign raw[P_TXA] = tx_aux_i;
  assign raw[P_RXA] = bus_a_rx_i | rx_a_en_ni;
  assign raw[P_RXB] = bus_b_rx_i | rx_b_en_ni;

  for (genvar g = 0; g < N_PATH; g++) begin : g_to
    dom_timeout #(.LIMIT(TIMEOUT_CYC)) u_to (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .lvl_i (raw[g]),
      .lvl_o (timed[g])
    );
  end

  // mask follows the registered drive, so no loop through the other bus
  for (genvar b = 0; b < N_BUS; b++) begin : g_bus
    echo_mask #(.HOLD(ECHO_CYC)) u_em (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .drv_i (drv_q[b]),
      .mask_o(mask[b])
    );
    assign rx_eff[b] = timed[P_RXA + b] | mask[b];
  end

  assign tx_any_rec = timed[P_TXM] & timed[P_TXA];
  assign drv_d[0]   = tx_any_rec & rx_eff[1];
  assign drv_d[1]   = tx_any_rec & rx_eff[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) drv_q <= {N_BUS{LVL_REC}};
    else         drv_q <= drv_d;
  end

  assign bus_a_drv_o = drv_q[0];
  assign bus_b_drv_o = drv_q[1];
  assign rxd_bus_o   = timed[P_RXA] & timed[P_RXB];
  assign rxd_all_o   = rxd_bus_o & tx_any_rec;

  p_gate_a_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_a_en_ni |-> timed[P_RXA]);

  p_gate_b_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_b_en_ni |-> timed[P_RXB]);

  p_fwd_ba_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_eff[1] |=> !bus_a_drv_o);

  p_fwd_ab_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_eff[0] |=> !bus_b_drv_o);

  p_tx_both_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_any_rec |=> (!bus_a_drv_o && !bus_b_drv_o));

  p_no_echo_a_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_a_drv_o |-> rx_eff[0]);

  p_rx_and_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rxd_bus_o |-> !rxd_all_o);
endmodule

// File: tb/dual_bus_relay_bench.sv
`timescale 1ns/1ps
module dual_bus_relay_bench;
  localparam int TO = 20;
  localparam int EC = 3;

  logic clk = 0;
  logic rst_n = 0;
  logic ext_a = 1, ext_b = 1, en_a_n = 0, en_b_n = 0, tx_m = 1, tx_x = 1;
  logic drv_a, drv_b, rxd_all, rxd_bus;
  logic rx_a, rx_b;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string tag = "R1";

  int   m_cnt[4];
  int   m_hold[2];
  logic m_drv[2];

  always #2.5 clk = ~clk;

  // drive output loops back onto its own bus, ANDed with other nodes
  assign rx_a = drv_a & ext_a;
  assign rx_b = drv_b & ext_b;

  dual_bus_relay #(.TIMEOUT_CYC(TO), .ECHO_CYC(EC)) u_dual_bus_relay (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .bus_a_rx_i (rx_a),
    .bus_b_rx_i (rx_b),
    .rx_a_en_ni (en_a_n),
    .rx_b_en_ni (en_b_n),
    .tx_main_i  (tx_m),
    .tx_aux_i   (tx_x),
    .bus_a_drv_o(drv_a),
    .bus_b_drv_o(drv_b),
    .rxd_all_o  (rxd_all),
    .rxd_bus_o  (rxd_bus)
  );

  task automatic chk(input string nm, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, nm, act, exp, $time);
    end
  endtask

  function automatic void model_reset();
    for (int i = 0; i < 4; i++) m_cnt[i] = 0;
    for (int i = 0; i < 2; i++) begin m_hold[i] = 0; m_drv[i] = 1; end
  endfunction

  function automatic logic tmd(input logic raw, input int c);
    return raw | (c == TO);
  endfunction

  // one cycle: apply inputs, compare, advance model
  task automatic step(input logic tm, input logic tx, input logic ea, input logic eb,
                      input logic na, input logic nb);
    logic raw[4];
    logic t[4];
    logic eff[2];
    logic txr;
    @(negedge clk);
    tx_m = tm; tx_x = tx; ext_a = ea; ext_b = eb; en_a_n = na; en_b_n = nb;
    #1;
    raw[0] = tm; raw[1] = tx;
    raw[2] = (m_drv[0] & ea) | na;
    raw[3] = (m_drv[1] & eb) | nb;
    for (int i = 0; i < 4; i++) t[i] = tmd(raw[i], m_cnt[i]);
    for (int b = 0; b < 2; b++) eff[b] = t[2+b] | (!m_drv[b]) | (m_hold[b] != 0);
    txr = t[0] & t[1];
    chk("bus_a_drv_o", drv_a, m_drv[0]);
    chk("bus_b_drv_o", drv_b, m_drv[1]);
    chk("rxd_bus_o", rxd_bus, t[2] & t[3]);
    chk("rxd_all_o", rxd_all, t[2] & t[3] & txr);
    for (int i = 0; i < 4; i++)
      m_cnt[i] = raw[i] ? 0 : ((m_cnt[i] == TO) ? TO : m_cnt[i] + 1);
    for (int b = 0; b < 2; b++)
      m_hold[b] = !m_drv[b] ? EC : ((m_hold[b] != 0) ? m_hold[b] - 1 : 0);
    m_drv[0] = txr & eff[1];
    m_drv[1] = txr & eff[0];
  endtask

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    tag = "R1";
    chk("bus_a_drv_o", drv_a, 1'b1);
    chk("bus_b_drv_o", drv_b, 1'b1);
    chk("rxd_all_o", rxd_all, 1'b1);
    chk("rxd_bus_o", rxd_bus, 1'b1);
    @(negedge clk);
    rst_n = 1;
    step(1, 1, 1, 1, 0, 0);

    // R5: transmit drives both, each bus forwards to the other
    tag = "R5";
    repeat (3) step(0, 1, 1, 1, 0, 0);
    repeat (8) step(1, 1, 1, 1, 0, 0);
    repeat (2) step(1, 1, 0, 1, 0, 0);
    repeat (8) step(1, 1, 1, 1, 0, 0);
    repeat (2) step(1, 1, 1, 0, 0, 0);
    repeat (8) step(1, 1, 1, 1, 0, 0);
    repeat (2) step(1, 0, 1, 1, 0, 0);
    repeat (8) step(1, 1, 1, 1, 0, 0);

    // R6: A dominant drives B; B echo must not return to A
    tag = "R6";
    repeat (3) step(1, 1, 0, 1, 0, 0);
    repeat (8) step(1, 1, 1, 1, 0, 0);

    // R7: genuine B dominant inside the tail is held off, then repeated
    tag = "R7";
    repeat (2) step(1, 1, 0, 1, 0, 0);
    repeat (7) step(1, 1, 1, 0, 0, 0);
    repeat (8) step(1, 1, 1, 1, 0, 0);

    // R3: stuck transmit and stuck bus input time out
    tag = "R3";
    repeat (TO + 6) step(0, 1, 1, 1, 0, 0);
    repeat (8) step(1, 1, 1, 1, 0, 0);
    repeat (TO + 6) step(1, 1, 0, 1, 0, 0);

    // R4: release and fresh dominant passes at once
    tag = "R4";
    step(1, 1, 1, 1, 0, 0);
    repeat (4) step(1, 1, 0, 1, 0, 0);
    repeat (8) step(1, 1, 1, 1, 0, 0);
    repeat (TO + 3) step(1, 0, 1, 1, 0, 0);
    step(1, 1, 1, 1, 0, 0);
    repeat (3) step(1, 0, 1, 1, 0, 0);
    repeat (8) step(1, 1, 1, 1, 0, 0);

    // R2: disabled receivers ignore their bus
    tag = "R2";
    repeat (10) step(1, 1, 0, 1, 1, 0);
    repeat (10) step(1, 1, 1, 0, 0, 1);
    repeat (6) step(1, 1, 0, 0, 1, 1);
    repeat (8) step(1, 1, 1, 1, 0, 0);

    // R8: random traffic, run-length style
    tag = "R8";
    begin
      logic tm, tx, ea, eb, na, nb;
      int seed;
      seed = $urandom(32'h5eed);
      tm = 1; tx = 1; ea = 1; eb = 1; na = 0; nb = 0;
      for (int k = 0; k < 3000; k++) begin
        if ($urandom_range(0, 11) == 0) tm = ~tm;
        if ($urandom_range(0, 15) == 0) tx = ~tx;
        if ($urandom_range(0, 7) == 0)  ea = ~ea;
        if ($urandom_range(0, 7) == 0)  eb = ~eb;
        na = ($urandom_range(0, 19) == 0);
        nb = ($urandom_range(0, 19) == 0);
        step(tm, tx, ea, eb, na, nb);
      end
    end

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog %s actual=running expected=finished", tag);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule